// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block generates the system reset for a microcontroller supervisor. It takes two asynchronous inputs. One is a supply-good flag from an external voltage threshold detector. The other is an active-low manual reset line that a push button, a logic gate or a watchdog output can drive. The block returns a clean reset as a complementary pair: an active-low output and an active-high output.

Both inputs first pass through a synchronizer. The manual line is then filtered, so that the block accepts a new level only after the line has held that level for a debounce interval (1 ms by default). This lets a mechanical switch drive the line directly. Reset is asserted while the supply is reported bad or while the filtered manual line is low. After both causes clear, reset stays asserted for a hold-off interval (200 ms by default) and then releases. If any cause returns during the hold-off, the full interval starts again. The block computes every interval in clock ticks from the `CLK_HZ` parameter.

The block has no watchdog input of its own. A watchdog timeout resets the system only when the watchdog output is wired to the manual line. Reset is asserted coming out of the power-on reset.

Top module: `rpg_reset_gen`

## Requirements
- R1: While `por_n` is low, and after it rises until the hold-off has run out, `sys_rst_n_o` is 0.
- R2: While `supply_ok_i` is 0, `sys_rst_n_o` is 0 without a break, from at most 3 clock cycles after the drop onward.
- R3: After `supply_ok_i` rises, with the manual line high, `sys_rst_n_o` rises HOLD_TICKS = CLK_HZ*HOLD_MS/1000 cycles later, plus a pipeline latency of at most 3 cycles.
- R4: A low level on `manr_n_i` that is held for at least DB_TICKS = CLK_HZ*DEBOUNCE_US/1000000 cycles drives `sys_rst_n_o` to 0 within DB_TICKS+5 cycles.
- R5: A low pulse on `manr_n_i` that is shorter than DB_TICKS cycles is ignored: `sys_rst_n_o` stays 1.
- R6: After `manr_n_i` returns high and stays high, `sys_rst_n_o` rises DB_TICKS+HOLD_TICKS cycles later, within a latency of 4 cycles.
- R7: `sys_rst_o` is always the exact inverse of `sys_rst_n_o`.
- R8: If a cause appears during the hold-off, the hold-off reloads to its full length. Release comes HOLD_TICKS after that cause clears, not at the original deadline.
- R9: Bounces on the release of the manual line, where each high run is shorter than DB_TICKS, do not end the manual cause. The debounce interval is measured from the last transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at CLK_HZ |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok_i | input | 1 | Supply above threshold when 1 (asynchronous) |
| manr_n_i | input | 1 | Manual reset request, active low (asynchronous, may bounce) |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high, inverse of sys_rst_n_o |

## Verification
The bench targets the edges of the two timing windows.

- **Hold-off measured from the wrong point.** A design that started the hold-off when the manual line rose, instead of after the debounce filter accepted the rise, would release reset too early on a bouncing button. A chattering release is used to expose this.
- **Hold-off not reloaded.** A supply dip in the middle of the hold-off shows up a design that keeps its original deadline instead of reloading, because it would release at the stale time.
- **Debounce that latches.** A low glitch just shorter than the debounce interval catches a filter that latches the first edge: such a design would pulse reset.
- **Exact release time.** The releases are checked against windows only a few cycles wide on either side of HOLD_TICKS, so a count that is off by a large amount or never expires is reported.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

   // Number of clock ticks in (amount / per_second) seconds at hz.
   function automatic longint unsigned rpg_ticks(input longint unsigned hz,
                                                 input longint unsigned amount,
                                                 input longint unsigned per_second);
      return (hz * amount) / per_second;
   endfunction

   // Bits needed to hold values 0..maxval.
   function automatic int unsigned rpg_width(input longint unsigned maxval);
      int unsigned w;
      w = 1;
      for (int i = 1; i < 64; i++) begin
         if ((64'd1 << i) <= maxval) w = i + 1;
      end
      return w;
   endfunction

endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rpg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rpg_debounce.sv
module rpg_debounce #(
   parameter int unsigned TICKS = 4,
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   output logic             level,
   output logic [CNT_W-1:0] run_cnt
);
   if (TICKS < 1) begin : g_bad_ticks
      $error("rpg_debounce: TICKS must be at least 1");
   end

   if (TICKS == 1) begin : g_bypass
      // A one-tick filter is the synchronizer itself.
      assign level   = raw;
      assign run_cnt = '0;
   end else begin : g_filter
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);
      logic             lvl_q;
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= 1'b1;
            cnt_q <= '0;
         end else if (raw == lvl_q) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            lvl_q <= raw;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign level   = lvl_q;
      assign run_cnt = cnt_q;
   end
endmodule

// File: rtl/rpg_holdoff.sv
module rpg_holdoff #(
   parameter longint unsigned TICKS = 8,
   parameter int unsigned     CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cause,
   output logic             rel_n,
   output logic [CNT_W-1:0] remain
);
   if (TICKS < 2) begin : g_bad_ticks
      $error("rpg_holdoff: TICKS must be at least 2");
   end

   localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= FULL;
         rel_q <= 1'b0;
      end else if (cause) begin
         cnt_q <= FULL;
         rel_q <= 1'b0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         rel_q <= (cnt_q == ONE);
      end else begin
         rel_q <= 1'b1;
      end
   end

   assign rel_n  = rel_q;
   assign remain = cnt_q;
endmodule

// File: rtl/rpg_reset_gen.sv
module rpg_reset_gen #(
   parameter longint unsigned CLK_HZ      = 125_000_000,
   parameter longint unsigned HOLD_MS     = 200,
   parameter longint unsigned DEBOUNCE_US = 1000,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic supply_ok_i,
   input  logic manr_n_i,
   output logic sys_rst_n_o,
   output logic sys_rst_o
);
   import rpg_pkg::*;

   localparam longint unsigned HOLD_TICKS = rpg_ticks(CLK_HZ, HOLD_MS, 1000);
   localparam longint unsigned DB_TICKS   = rpg_ticks(CLK_HZ, DEBOUNCE_US, 1_000_000);
   localparam int unsigned     HOLD_W     = rpg_width(HOLD_TICKS);
   localparam int unsigned     DB_W       = rpg_width(DB_TICKS);

   if (CLK_HZ == 0) begin : g_bad_clk
      $error("rpg_reset_gen: CLK_HZ must be nonzero");
   end

   logic              supply_s;
   logic              manr_s;
   logic              manr_lvl;
   logic [DB_W-1:0]   db_cnt;
   logic [HOLD_W-1:0] hold_cnt;
   logic              any_cause;
   logic              rel_n;

   // The supply is taken as bad and the button as released until sampled.
   rpg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sup (
      .clk(clk), .rst_n(por_n), .d(supply_ok_i), .q(supply_s));

   rpg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_man (
      .clk(clk), .rst_n(por_n), .d(manr_n_i), .q(manr_s));

   rpg_debounce #(.TICKS(int'(DB_TICKS)), .CNT_W(DB_W)) u_db (
      .clk(clk), .rst_n(por_n), .raw(manr_s), .level(manr_lvl), .run_cnt(db_cnt));

   assign any_cause = !supply_s || !manr_lvl;

   rpg_holdoff #(.TICKS(HOLD_TICKS), .CNT_W(HOLD_W)) u_hold (
      .clk(clk), .rst_n(por_n), .cause(any_cause), .rel_n(rel_n), .remain(hold_cnt));

   assign sys_rst_n_o = rel_n;
   assign sys_rst_o   = !rel_n;
endmodule

// File: rtl/rpg_reset_gen_chk.sv
module rpg_reset_gen_chk #(
   parameter longint unsigned HOLD_TICKS = 8,
   parameter longint unsigned DB_TICKS   = 4,
   parameter int unsigned     HOLD_W     = 4,
   parameter int unsigned     DB_W       = 3
) (
   input logic              clk,
   input logic              por_n,
   input logic              supply_s,
   input logic              manr_lvl,
   input logic [DB_W-1:0]   db_cnt,
   input logic [HOLD_W-1:0] hold_cnt,
   input logic              sys_rst_n_o,
   input logic              sys_rst_o
);
   always @(posedge clk) begin
      if (!por_n) begin
         assert_por_low_R1: assert (!sys_rst_n_o)
            else $error("reset output released during power-on reset");
      end
   end

   assert_supply_holds_R2: assert property (@(posedge clk) disable iff (!por_n)
      !supply_s |=> !sys_rst_n_o);

   assert_release_after_count_R3: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst_n_o) |-> ($past(hold_cnt) == HOLD_W'(1) && $past(supply_s) && $past(manr_lvl)));

   assert_manual_holds_R4: assert property (@(posedge clk) disable iff (!por_n)
      !manr_lvl |=> !sys_rst_n_o);

   assert_filter_accept_R5: assert property (@(posedge clk) disable iff (!por_n)
      !$stable(manr_lvl) |-> ($past(db_cnt) == DB_W'(DB_TICKS - 1)));

   assert_pair_inverse_R7: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst_o == !sys_rst_n_o);

   assert_reload_full_R8: assert property (@(posedge clk) disable iff (!por_n)
      (!supply_s || !manr_lvl) |=> (hold_cnt == HOLD_W'(HOLD_TICKS)));
endmodule

bind rpg_reset_gen rpg_reset_gen_chk #(
   .HOLD_TICKS(HOLD_TICKS), .DB_TICKS(DB_TICKS), .HOLD_W(HOLD_W), .DB_W(DB_W)
) u_chk (
   .clk(clk), .por_n(por_n), .supply_s(supply_s), .manr_lvl(manr_lvl),
   .db_cnt(db_cnt), .hold_cnt(hold_cnt),
   .sys_rst_n_o(sys_rst_n_o), .sys_rst_o(sys_rst_o));

// File: tb/tb_rpg_reset_gen.sv
module tb_rpg_reset_gen;
   // 20 kHz nominal rate keeps the intervals short: 4000-tick hold, 20-tick filter.
   localparam longint unsigned T_HZ = 20_000;
   localparam int HOLD = 4000;   // 20000 * 200 / 1000
   localparam int DB   = 20;     // 20000 * 1000 / 1000000

   logic clk = 1'b0;
   logic por_n = 1'b1;
   logic supply_ok_i = 1'b0;
   logic manr_n_i = 1'b1;
   logic sys_rst_n_o, sys_rst_o;

   int cyc = 0;
   int total = 0;
   int bad = 0;

   typedef struct {
      int    at;
      bit    lvl;
      string req;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc <= cyc + 1;

   rpg_reset_gen #(.CLK_HZ(T_HZ)) dut (
      .clk(clk), .por_n(por_n), .supply_ok_i(supply_ok_i), .manr_n_i(manr_n_i),
      .sys_rst_n_o(sys_rst_n_o), .sys_rst_o(sys_rst_o));

   // Driver side: push the level expected on sys_rst_n_o after edge 'at'.
   task automatic expect_lvl(input int at, input bit lvl, input string req);
      exp_t e;
      e.at = at; e.lvl = lvl; e.req = req;
      sb.push_back(e);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_now(input bit lvl, input string req);
      total++;
      if (sys_rst_n_o !== lvl || sys_rst_o !== !lvl) begin
         bad++;
         $display("FAIL %s cyc=%0d rst_n=%b rst=%b expected rst_n=%b rst=%b",
                  req, cyc, sys_rst_n_o, sys_rst_o, lvl, !lvl);
      end
   endtask

   // Monitor: compare every item due at this cycle.
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].at == cyc) begin
            check_now(sb[i].lvl, {sb[i].req, " R7"});
            sb.delete(i);
         end
      end
   end

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      bad++;
      $display("FAIL watchdog cyc=%0d pending=%0d expected=0", cyc, sb.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      int c0;
      #1 por_n = 1'b0;
      step(3);
      check_now(1'b0, "R1 reset during por");
      por_n = 1'b1;
      step(1);
      c0 = cyc;
      expect_lvl(c0 + 5, 1'b0, "R1 after por");
      expect_lvl(c0 + 500, 1'b0, "R2 supply still bad");
      step(600);

      // Supply comes good: release after the hold-off.
      supply_ok_i = 1'b1;
      c0 = cyc;
      expect_lvl(c0 + HOLD, 1'b0, "R3 before hold-off end");
      expect_lvl(c0 + HOLD + 3, 1'b1, "R3 released");
      step(HOLD + 20);

      // Short glitch on the manual line is ignored.
      manr_n_i = 1'b0;
      c0 = cyc;
      step(DB - 4);
      manr_n_i = 1'b1;
      expect_lvl(c0 + DB + 2, 1'b1, "R5 glitch ignored");
      expect_lvl(c0 + DB + 10, 1'b1, "R5 glitch ignored");
      expect_lvl(c0 + DB + 200, 1'b1, "R5 glitch ignored");
      step(DB + 220);

      // Real press, held, then clean release.
      manr_n_i = 1'b0;
      c0 = cyc;
      expect_lvl(c0 + 2, 1'b1, "R4 not yet accepted");
      expect_lvl(c0 + DB + 5, 1'b0, "R4 press accepted");
      step(80);
      manr_n_i = 1'b1;
      c0 = cyc;
      expect_lvl(c0 + DB + HOLD, 1'b0, "R6 before hold-off end");
      expect_lvl(c0 + DB + HOLD + 4, 1'b1, "R6 released");
      step(DB + HOLD + 20);

      // Press with bouncing release: timing counts from the final edge.
      manr_n_i = 1'b0;
      step(60);
      for (int b = 0; b < 3; b++) begin
         manr_n_i = 1'b1; step(DB / 2);
         manr_n_i = 1'b0; step(DB / 4);
      end
      manr_n_i = 1'b1;
      c0 = cyc;
      expect_lvl(c0 + DB + HOLD, 1'b0, "R9 bounce before end");
      expect_lvl(c0 + DB + HOLD + 4, 1'b1, "R9 bounce released");
      step(DB + HOLD + 20);

      // Supply dip in the middle of a hold-off reloads the full count.
      manr_n_i = 1'b0;
      step(60);
      manr_n_i = 1'b1;
      c0 = cyc;
      step(DB + HOLD / 2);
      supply_ok_i = 1'b0;
      expect_lvl(cyc + 6, 1'b0, "R2 dip asserts");
      step(10);
      supply_ok_i = 1'b1;
      expect_lvl(c0 + DB + HOLD + 4, 1'b0, "R8 old deadline ignored");
      expect_lvl(cyc + HOLD, 1'b0, "R8 reloaded before end");
      expect_lvl(cyc + HOLD + 3, 1'b1, "R8 reloaded released");
      step(HOLD + 20);

      // Brief supply dip during normal operation.
      supply_ok_i = 1'b0;
      c0 = cyc;
      expect_lvl(c0 + 4, 1'b0, "R2 drop seen");
      expect_lvl(c0 + 40, 1'b0, "R2 held while bad");
      step(50);
      supply_ok_i = 1'b1;
      c0 = cyc;
      expect_lvl(c0 + HOLD + 3, 1'b1, "R3 release after dip");
      step(HOLD + 20);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule